// File: doc/BRIEF.md
# Interrupt Vector Fetch Insertion Sequencer

This block sits between the fetch stage of a three-stage fetch/decode/execute pipeline and program memory. When it accepts an interrupt request, it replaces the next two program-counter fetches with fetches from the request's vector start address and the word after it. The program counter is held while those two words are fetched, so that normal fetching resumes at the word that would have been fetched anyway.

The block also applies the pipeline rules around the insertion. An instruction whose fetch would be disturbed by the insertion is squashed and fetched again after the vector pair. A true conditional trap that is decoded while the first vector word is being fetched makes the block discard that fetch and fetch the two trap vector words instead. A minimum decode spacing is kept between consecutive insertions, and no request is accepted while a repeat loop is running. A one-cycle acknowledge tells the request logic when the second vector word of its request has been fetched.

A request is accepted in a cycle where `req_valid` is high, the sequencer is not in a vector or refetch slot, the spacing rule is met and `rep_active` is low. The first vector fetch follows in the next cycle.

Top module: `ivec_inserter`

## Requirements
- R1: In the cycle after acceptance `fetch_addr` equals `req_vec`, and in the cycle after that it equals `req_vec + 1`.
- R2: `pc_hold` is high in both vector fetch cycles and in the refetch cycle and low in every other cycle. When nothing was squashed, `fetch_addr` equals `pc` again in the cycle after the second vector fetch.
- R3: `vec_fetch` is high exactly in the cycles that fetch a vector word. A vector pair whose second word has been fetched is never squashed: `squash` is low in the cycle after a second vector fetch.
- R4: If the acceptance cycle's word was squashed, then in the cycle after the second vector fetch `fetch_addr` equals the address fetched in the acceptance cycle, with `refetch` and `pc_hold` high.
- R5: `fetch_kind` codes the word fetched in the current cycle as follows: 2'b00 plain one-word, 2'b01 one-word change-of-flow/repeat/stop/wait/reset, 2'b10 first word of a two-word instruction, 2'b11 second word of a two-word instruction. Codes 2'b01 and 2'b10 in the acceptance cycle raise `squash` in the first vector cycle. Codes 2'b00 and 2'b11 raise neither `squash` nor a refetch.
- R6: With `rep_active` low, two consecutive first-vector fetches are at least five cycles apart. This guarantees four decoded instructions after the first vector word before the next one.
- R7: No request is accepted in a cycle where `rep_active` is high. Cycles with `rep_active` high that follow a second vector fetch do not count toward the R6 spacing.
- R8: If `trap_hit` is high in a first-vector cycle, `squash` is high in the next cycle. That cycle and the one after fetch `trap_vec` and `trap_vec + 1`, and no `vec_ack` is given for that pair.
- R9: `vec_ack` is a single-cycle pulse, high in the second vector fetch cycle of an accepted request and at no other time.
- R10: While `rst_n` is low (synchronous), `fetch_addr` follows `pc` and `pc_hold`, `squash`, `refetch`, `vec_ack` and `vec_fetch` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc | input | AW | Current program counter |
| req_valid | input | 1 | Pending interrupt request |
| req_vec | input | AW | Vector start address of the pending request |
| fetch_kind | input | 2 | Class of the word fetched this cycle (R5) |
| rep_active | input | 1 | Repeated instruction is running, fetch suspended |
| trap_hit | input | 1 | A conditional trap with a true condition is in decode |
| trap_vec | input | AW | Trap vector start address |
| fetch_addr | output | AW | Program memory fetch address |
| pc_hold | output | 1 | Program counter must not advance this cycle |
| squash | output | 1 | Word fetched in the previous cycle is discarded |
| refetch | output | 1 | This fetch re-issues a squashed instruction |
| vec_ack | output | 1 | Second vector word of the request fetched |
| vec_fetch | output | 1 | This fetch is a vector word that must execute |

## Verification
The hardest situation to reach is a trap override that lands on a vector pair whose acceptance already squashed an instruction. Three things must line up in it: a discarded first vector, the trap pair, and the refetch of the original word. `trap_hit` has to rise exactly in the first-vector cycle, so the bench raises it from its own model's prediction of that cycle. It also runs a long pseudo-random phase that mixes word classes, repeat windows and held requests, and compares every output against the behavioural model on every clock. The spacing and repeat rules are checked again directly from the observed rises of `vec_fetch`.

// File: rtl/ivs_pkg.sv
// Shared types for the interrupt vector fetch insertion sequencer.
package ivs_pkg;
    // Class of the word in the fetch slot (code values are part of the port contract).
    typedef enum logic [1:0] {
        FK_PLAIN = 2'b00,
        FK_FLOW  = 2'b01,
        FK_LEAD  = 2'b10,
        FK_TAIL  = 2'b11
    } fetch_kind_t;

    // Fetch-slot owner.
    typedef enum logic [1:0] {
        SQ_RUN  = 2'b00,
        SQ_VEC0 = 2'b01,
        SQ_VEC1 = 2'b10,
        SQ_REDO = 2'b11
    } seq_state_t;
endpackage

// File: rtl/ivs_gap.sv
// Spacing counter between vector insertions.
// Loaded when the second vector word is fetched, then counts decode cycles
// (cycles with no repeat loop running). A new acceptance is allowed once it
// reaches zero. Assumes MIN_GAP >= 2.
module ivs_gap #(
    parameter int MIN_GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic clear
);
    localparam int RELOAD = MIN_GAP - 2;
    localparam int CW     = $clog2(MIN_GAP + 1);

    logic [CW-1:0] left;

    // Count down the decodes still owed before the next insertion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left <= '0;
        else if (load)
            left <= CW'(RELOAD);
        else if (tick && left != '0)
            left <= left - 1'b1;
    end

    assign clear = (left == '0);
endmodule

// File: rtl/ivs_ctrl.sv
// Slot sequencer: decides acceptance, trap override, squash and refetch.
// Assumes fetch_kind describes the word fetched in the current cycle and
// trap_hit is only meaningful in a first-vector cycle.
module ivs_ctrl
    import ivs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        rep_active,
    input  logic        gap_clear,
    input  logic        trap_hit,
    input  fetch_kind_t kind,
    output seq_state_t  seq_st,
    output logic        accept,
    output logic        trap_take,
    output logic        squash,
    output logic        refetch,
    output logic        vec_ack,
    output logic        pc_hold,
    output logic        vec_fetch
);
    seq_state_t nxt;
    logic       redo_pend;
    logic       from_trap;
    logic       abortable;

    // Acceptance, trap override and abort classification.
    always_comb begin
        accept    = (seq_st == SQ_RUN) && req_valid && gap_clear && !rep_active;
        trap_take = (seq_st == SQ_VEC0) && trap_hit;
        abortable = (kind == FK_FLOW) || (kind == FK_LEAD);
    end

    // Next slot owner.
    always_comb begin
        nxt = seq_st;
        unique case (seq_st)
            SQ_RUN:  if (accept) nxt = SQ_VEC0;
            SQ_VEC0: if (!trap_take) nxt = SQ_VEC1;
            SQ_VEC1: nxt = redo_pend ? SQ_REDO : SQ_RUN;
            SQ_REDO: nxt = SQ_RUN;
            default: nxt = SQ_RUN;
        endcase
    end

    // Slot state and the flags that travel with the current insertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_st    <= SQ_RUN;
            redo_pend <= 1'b0;
            from_trap <= 1'b0;
            squash    <= 1'b0;
        end else begin
            seq_st <= nxt;
            squash <= (accept && abortable) || trap_take;
            if (accept)
                redo_pend <= abortable;
            else if (seq_st == SQ_REDO)
                redo_pend <= 1'b0;
            if (accept)
                from_trap <= 1'b0;
            else if (trap_take)
                from_trap <= 1'b1;
        end
    end

    // Per-slot outputs.
    always_comb begin
        vec_fetch = (seq_st == SQ_VEC0) || (seq_st == SQ_VEC1);
        vec_ack   = (seq_st == SQ_VEC1) && !from_trap;
        refetch   = (seq_st == SQ_REDO);
        pc_hold   = (seq_st != SQ_RUN);
    end
endmodule

// File: rtl/ivs_addr.sv
// Fetch address path: keeps the active vector base and the address to
// re-issue after a squash, and selects the fetch address per slot.
module ivs_addr
    import ivs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          trap_take,
    input  seq_state_t    seq_st,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] req_vec,
    input  logic [AW-1:0] trap_vec,
    output logic [AW-1:0] fetch_addr
);
    logic [AW-1:0] base;
    logic [AW-1:0] resume;

    // Capture the vector base and the address fetched at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base   <= '0;
            resume <= '0;
        end else if (accept) begin
            base   <= req_vec;
            resume <= pc;
        end else if (trap_take) begin
            base   <= trap_vec;
        end
    end

    // Slot-dependent fetch address.
    always_comb begin
        unique case (seq_st)
            SQ_VEC0: fetch_addr = base;
            SQ_VEC1: fetch_addr = base + 1'b1;
            SQ_REDO: fetch_addr = resume;
            default: fetch_addr = pc;
        endcase
    end
endmodule

// File: rtl/ivec_inserter.sv
// Interrupt vector fetch insertion sequencer (top).
// Substitutes two vector fetches for program-counter fetches on acceptance,
// squashes and re-issues a disturbed instruction, honours trap override and
// keeps a minimum decode spacing between insertions. Request arbitration and
// program-counter arithmetic live outside; pc must stop while pc_hold is high.
module ivec_inserter
    import ivs_pkg::*;
#(
    parameter int AW      = 16,
    parameter int MIN_GAP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] pc,
    input  logic          req_valid,
    input  logic [AW-1:0] req_vec,
    input  logic [1:0]    fetch_kind,
    input  logic          rep_active,
    input  logic          trap_hit,
    input  logic [AW-1:0] trap_vec,
    output logic [AW-1:0] fetch_addr,
    output logic          pc_hold,
    output logic          squash,
    output logic          refetch,
    output logic          vec_ack,
    output logic          vec_fetch
);
    seq_state_t seq_st;
    logic       accept;
    logic       trap_take;
    logic       gap_clear;

    ivs_gap #(.MIN_GAP(MIN_GAP)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (seq_st == SQ_VEC1),
        .tick  (!rep_active),
        .clear (gap_clear)
    );

    ivs_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .rep_active (rep_active),
        .gap_clear  (gap_clear),
        .trap_hit   (trap_hit),
        .kind       (fetch_kind_t'(fetch_kind)),
        .seq_st     (seq_st),
        .accept     (accept),
        .trap_take  (trap_take),
        .squash     (squash),
        .refetch    (refetch),
        .vec_ack    (vec_ack),
        .pc_hold    (pc_hold),
        .vec_fetch  (vec_fetch)
    );

    ivs_addr #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .trap_take  (trap_take),
        .seq_st     (seq_st),
        .pc         (pc),
        .req_vec    (req_vec),
        .trap_vec   (trap_vec),
        .fetch_addr (fetch_addr)
    );
endmodule

// File: rtl/ivec_inserter_chk.sv
// Property checker for ivec_inserter, attached by bind below.
module ivec_inserter_chk
    import ivs_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] fetch_addr,
    input logic          pc_hold,
    input logic          squash,
    input logic          refetch,
    input logic          vec_ack,
    input logic          vec_fetch,
    input logic          rep_active,
    input seq_state_t    seq_st
);
    // R1: second vector fetch follows the first at the next address.
    p_second_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == SQ_VEC1) |-> fetch_addr == AW'($past(fetch_addr) + 1'b1));

    // R2: the program counter is held while a vector word is fetched.
    p_hold_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_fetch |-> pc_hold);

    // R3: a fetched vector pair is never squashed.
    p_pair_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == SQ_VEC1) |=> !squash);

    // R4: a refetch directly follows a second vector fetch, with pc held.
    p_redo_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        refetch |-> ($past(seq_st) == SQ_VEC1) && pc_hold);

    // R7: no acceptance while a repeat loop runs.
    p_rep_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_active && seq_st == SQ_RUN) |=> (seq_st == SQ_RUN));

    // R9: acknowledge is one cycle wide.
    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_ack |=> !vec_ack);

    // R9: acknowledge only in a second vector fetch.
    p_ack_second_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_ack |-> (vec_fetch && $past(vec_fetch)));
endmodule

bind ivec_inserter ivec_inserter_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_addr (fetch_addr),
    .pc_hold    (pc_hold),
    .squash     (squash),
    .refetch    (refetch),
    .vec_ack    (vec_ack),
    .vec_fetch  (vec_fetch),
    .rep_active (rep_active),
    .seq_st     (seq_st)
);

// File: tb/test_ivec_inserter.sv
// Bench: behavioural slot-queue model compared with the design every clock.
module test_ivec_inserter;
    localparam int AW      = 16;
    localparam int MIN_GAP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] pc = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_vec = '0;
    logic [1:0]    fetch_kind = 2'b00;
    logic          rep_active = 1'b0;
    logic          trap_hit = 1'b0;
    logic [AW-1:0] trap_vec = '0;
    logic [AW-1:0] fetch_addr;
    logic          pc_hold, squash, refetch, vec_ack, vec_fetch;

    ivec_inserter #(.AW(AW), .MIN_GAP(MIN_GAP)) i_ivec_inserter (
        .clk(clk), .rst_n(rst_n), .pc(pc), .req_valid(req_valid), .req_vec(req_vec),
        .fetch_kind(fetch_kind), .rep_active(rep_active), .trap_hit(trap_hit),
        .trap_vec(trap_vec), .fetch_addr(fetch_addr), .pc_hold(pc_hold),
        .squash(squash), .refetch(refetch), .vec_ack(vec_ack), .vec_fetch(vec_fetch)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Stimulus controls set by scenarios.
    bit            g_req = 0, g_rep = 0, g_trap_arm = 0, g_auto_drop = 0;
    logic [AW-1:0] g_vec = '0, g_trapv = '0;
    logic [1:0]    g_kind = 2'b00;

    // Model: queue of pending fetch slots (tag 1 first vec, 2 second vec, 3 refetch).
    int  qa[$];
    int  qt[$];
    int  qk[$];
    int  gapcnt = 1000;
    bit  sq_now = 0;
    logic [AW-1:0] pc_next = 16'h0100;
    int  cyc = 0;
    int  last_rise = -100;
    bit  prev_vf = 0, prev_rep = 0;
    bit  saw_trap_addr = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step();
        int  t;
        bit  e_vf, e_hold, e_redo, e_ack, sq_next;
        int  e_addr;
        @(negedge clk);
        pc         = pc_next;
        t          = (qt.size() > 0) ? qt[0] : 0;
        trap_hit   = g_trap_arm && (t == 1);
        req_valid  = g_req;
        req_vec    = g_vec;
        fetch_kind = g_kind;
        rep_active = g_rep;
        trap_vec   = g_trapv;
        #1;
        e_addr = (t != 0) ? qa[0] : int'(pc);
        e_vf   = (t == 1) || (t == 2);
        e_hold = (t != 0);
        e_redo = (t == 3);
        e_ack  = (t == 2) && (qk[0] == 1);
        chk(int'(fetch_addr) == e_addr, (t == 3) ? "R4 refetch address" : "R1 fetch address",
            int'(fetch_addr), e_addr);
        chk(pc_hold == e_hold, "R2 pc_hold", int'(pc_hold), int'(e_hold));
        chk(vec_fetch == e_vf, "R3 vec_fetch", int'(vec_fetch), int'(e_vf));
        chk(refetch == e_redo, "R4 refetch", int'(refetch), int'(e_redo));
        chk(squash == sq_now, "R5 squash", int'(squash), int'(sq_now));
        chk(vec_ack == e_ack, "R9 vec_ack", int'(vec_ack), int'(e_ack));
        if (trap_hit) saw_trap_addr = 0;
        if (vec_fetch && fetch_addr == g_trapv && g_trap_arm) saw_trap_addr = 1;
        // R6 / R7: observed rise of vec_fetch.
        if (vec_fetch && !prev_vf && fetch_addr != g_trapv) begin
            chk(cyc - last_rise >= MIN_GAP + 1, "R6 spacing", cyc - last_rise, MIN_GAP + 1);
            chk(!prev_rep, "R7 accepted during repeat", int'(prev_rep), 0);
            last_rise = cyc;
        end
        prev_vf  = vec_fetch;
        prev_rep = rep_active;
        // Model update for the coming edge.
        sq_next = 0;
        if (t != 0) begin
            void'(qa.pop_front()); void'(qt.pop_front()); void'(qk.pop_front());
            if (t == 1 && trap_hit) begin
                void'(qa.pop_front()); void'(qt.pop_front()); void'(qk.pop_front());
                qa.push_front(int'(AW'(g_trapv + 1))); qt.push_front(2); qk.push_front(0);
                qa.push_front(int'(g_trapv));          qt.push_front(1); qk.push_front(0);
                sq_next = 1;
            end
        end else if (g_req && !g_rep && gapcnt >= MIN_GAP - 2) begin
            qa.push_back(int'(g_vec));            qt.push_back(1); qk.push_back(0);
            qa.push_back(int'(AW'(g_vec + 1)));   qt.push_back(2); qk.push_back(1);
            if (g_kind == 2'b01 || g_kind == 2'b10) begin
                qa.push_back(int'(pc)); qt.push_back(3); qk.push_back(0);
                sq_next = 1;
            end
        end
        if (t == 2) gapcnt = 0;
        else if (!g_rep && gapcnt < 1000) gapcnt++;
        sq_now  = sq_next;
        pc_next = e_hold ? pc : AW'(pc + 1);
        if (e_ack && g_auto_drop) g_req = 0;
        cyc++;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        // R10: reset state.
        pc = 16'h0100; pc_next = 16'h0100;
        req_valid = 1'b1; req_vec = 16'h0040;
        repeat (3) @(negedge clk);
        #1;
        chk(fetch_addr == 16'h0100, "R10 reset fetch_addr", int'(fetch_addr), 'h100);
        chk({pc_hold, squash, refetch, vec_ack, vec_fetch} == 5'b0, "R10 reset flags",
            int'({pc_hold, squash, refetch, vec_ack, vec_fetch}), 0);
        rst_n = 1'b1;
        req_valid = 1'b0;

        // R1, R2, R9: plain word at acceptance.
        g_auto_drop = 1; g_vec = 16'h0040; g_kind = 2'b00; g_req = 1;
        run(10);
        // R4, R5: one-word change of flow squashed and re-issued.
        g_vec = 16'h0080; g_kind = 2'b01; g_req = 1;
        run(10);
        // R5: first word of a two-word instruction.
        g_vec = 16'h00A0; g_kind = 2'b10; g_req = 1;
        run(10);
        // R5: second word completes normally.
        g_vec = 16'h00C0; g_kind = 2'b11; g_req = 1;
        run(10);
        // R6: request held level, back-to-back insertions.
        g_auto_drop = 0; g_kind = 2'b00; g_vec = 16'h0010; g_req = 1;
        run(24);
        g_req = 0;
        run(6);
        // R7: repeat loop blocks acceptance and stalls spacing.
        g_req = 1; g_vec = 16'h0020;
        run(3);
        g_rep = 1;
        run(6);
        g_rep = 0;
        run(10);
        g_req = 0;
        run(6);
        // R8: trap override on a squashing acceptance.
        g_auto_drop = 1; g_trap_arm = 1; g_trapv = 16'h0006; g_vec = 16'h0030;
        g_kind = 2'b01; g_req = 1;
        run(6);
        chk(saw_trap_addr, "R8 trap vector fetched", int'(saw_trap_addr), 1);
        g_trap_arm = 0; g_kind = 2'b00;
        run(12);
        g_req = 0;
        run(4);
        // Mixed pseudo-random phase (all requirements).
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            g_kind     = lfsr[1:0];
            g_rep      = (lfsr[6:4] == 3'b111);
            g_trap_arm = (lfsr[9:8] == 2'b11);
            g_auto_drop = lfsr[11];
            if (!g_req && lfsr[3]) begin
                g_req = 1;
                g_vec = {8'h02, lfsr[15:10], 2'b00};
            end
            step();
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule